// File: doc/BRIEF.md
# Left/Right Line Splitter

This block sits between a single-stream pixel pipeline and two display serial outputs that are clocked together. In split mode it cuts every incoming line into a left half and a right half. The left half goes to output lane 0 and the right half to output lane 1. Both halves leave side by side, so each lane carries half the line width and runs at half the input pixel rate. In bypass mode the whole stream passes to lane 0 and lane 1 stays quiet.

Software programs four configuration words through a small write port: frame width, frame height, a routing word and a split-enable word. Writes land in shadow registers. The block copies them into its working set on the pixel that carries the frame-start marker, so a frame never changes routing partway through. The left half of a line is held in a half-line buffer. Each right-half pixel, as it arrives, is paired with the stored left pixel at the same offset. The two lanes therefore start every line on the same cycle.

Top module: `lr_line_splitter`

## Requirements
- R1: Configuration writes use `cfg_addr`: 0 is frame width, 1 is frame height, 2 is the routing word (its low four bits are kept), and 3 is split enable (bit 0). All four are shadow values.
- R2: Split routing is selected only when routing bits 3 and 0 are both 1, routing bit 2 is 0, split enable bit 0 is 1, and the width is legal. Every other combination selects bypass. Routing bit 2 alone, or with bits 3 and 0, means bypass.
- R3: In bypass, lane 0 repeats the input valid, line-start, frame-start and pixel one cycle after each input cycle, and lane 1 stays idle.
- R4: In split mode, column numbering restarts at 0 on each line-start pixel, and W is the programmed width. When the input pixel at column W/2+k arrives, one cycle later lane 0 carries the stored column-k pixel and lane 1 carries the arriving pixel, both valid in the same cycle.
- R5: In split mode, both lanes raise line-start on their first pixel of each line (k = 0). They raise frame-start only on that pixel of line 0 of the frame.
- R6: In split mode, pixels at column W or above, and lines at index equal to or above the programmed height, produce no output. The frame-start pixel is line 0, and each later line-start adds one.
- R7: A frame that requests split with a width that is odd, zero, or above MAX_WIDTH is passed in bypass. It also sets `cfg_err`, which stays 1 until reset.
- R8: Configuration writes made during a frame do not change how that frame is routed. They take effect from the next valid frame-start pixel onward.
- R9: Whenever a lane is not valid, its pixel, line-start and frame-start outputs are 0. A lane is valid only in the cycle after a valid input pixel.
- R10: After reset both lanes are idle, `cfg_err` is 0, and the block bypasses, because every configuration word resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | CFG_W | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_sol | input | 1 | Input line-start marker |
| in_sof | input | 1 | Input frame-start marker |
| in_pix | input | PIX_W | Input pixel |
| out0_valid | output | 1 | Lane 0 valid |
| out0_sol | output | 1 | Lane 0 line-start |
| out0_sof | output | 1 | Lane 0 frame-start |
| out0_pix | output | PIX_W | Lane 0 pixel |
| out1_valid | output | 1 | Lane 1 valid |
| out1_sol | output | 1 | Lane 1 line-start |
| out1_sof | output | 1 | Lane 1 frame-start |
| out1_pix | output | PIX_W | Lane 1 pixel |
| cfg_err | output | 1 | Sticky illegal-width flag |

## Verification
Each internal fault shows at the ports within a known number of cycles:

- A wrong column or line counter shows up within one line as a lane valid in the wrong cycle, or as a misplaced line-start.
- A corrupt half-line buffer word shows up as a wrong lane 0 pixel in the cycle after the matching right-half pixel arrives.
- A working configuration loaded at the wrong moment appears on the first pixel after the stray write, as a route change in the middle of a frame.
- A lost error bit appears on the next frame that requests split.

The bench runs random frame sizes, gaps and routing words next to directed odd, oversize and maximum widths, so each of these faults reaches a compared output.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  typedef enum logic {
    ROUTE_BYPASS = 1'b0,
    ROUTE_SPLIT  = 1'b1
  } route_e;

  // Routing word asks for split: bits 3 and 0 set, bit 2 clear, enable set.
  function automatic logic split_requested(logic [3:0] mode, logic enable);
    return mode[3] & mode[0] & ~mode[2] & enable;
  endfunction

  function automatic logic width_legal(int unsigned w, int unsigned maxw);
    return (w != 0) && ((w % 2) == 0) && (w <= maxw);
  endfunction

  function automatic route_e route_decode(logic [3:0] mode, logic enable, logic legal);
    return (split_requested(mode, enable) && legal) ? ROUTE_SPLIT : ROUTE_BYPASS;
  endfunction

  function automatic int unsigned half_of(int unsigned w);
    return w / 2;
  endfunction

endpackage

// File: rtl/lrs_cfg.sv
module lrs_cfg
  import lrs_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int MAX_WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             frame_load,
  output logic [CFG_W-1:0] eff_width,
  output logic [CFG_W-1:0] eff_height,
  output route_e           eff_route,
  output route_e           route_q,
  output logic             err
);

  logic [CFG_W-1:0] sh_width, sh_height, act_width, act_height;
  logic [3:0]       sh_mode;
  logic             sh_split;
  logic             sh_legal;
  route_e           sh_route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_width  <= '0;
      sh_height <= '0;
      sh_mode   <= '0;
      sh_split  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0:    sh_width  <= cfg_wdata;
        2'd1:    sh_height <= cfg_wdata;
        2'd2:    sh_mode   <= cfg_wdata[3:0];
        default: sh_split  <= cfg_wdata[0];
      endcase
    end
  end

  always_comb begin
    sh_legal = width_legal(32'(sh_width), MAX_WIDTH);
    sh_route = route_decode(sh_mode, sh_split, sh_legal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_width  <= '0;
      act_height <= '0;
      route_q    <= ROUTE_BYPASS;
      err        <= 1'b0;
    end else if (frame_load) begin
      act_width  <= sh_width;
      act_height <= sh_height;
      route_q    <= sh_route;
      if (split_requested(sh_mode, sh_split) && !sh_legal) err <= 1'b1;
    end
  end

  // The frame-start pixel itself already follows the new settings.
  assign eff_width  = frame_load ? sh_width  : act_width;
  assign eff_height = frame_load ? sh_height : act_height;
  assign eff_route  = frame_load ? sh_route  : route_q;

endmodule

// File: rtl/lrs_pos.sv
module lrs_pos #(
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic             in_sof,
  output logic [CFG_W-1:0] cur_col,
  output logic [CFG_W-1:0] cur_row
);

  logic [CFG_W-1:0] col_q, row_q;

  always_comb begin
    cur_col = in_sol ? '0 : col_q;
    if (in_sof)      cur_row = '0;
    else if (in_sol) cur_row = row_q + 1'b1;
    else             cur_row = row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (in_valid) begin
      col_q <= cur_col + 1'b1;
      row_q <= cur_row;
    end
  end

endmodule

// File: rtl/lrs_halfbuf.sv
module lrs_halfbuf #(
  parameter int DEPTH = 32,
  parameter int PIX_W = 24,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);

  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/lr_line_splitter.sv
module lr_line_splitter
  import lrs_pkg::*;
#(
  parameter int PIX_W     = 24,
  parameter int CFG_W     = 16,
  parameter int MAX_WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out0_valid,
  output logic             out0_sol,
  output logic             out0_sof,
  output logic [PIX_W-1:0] out0_pix,
  output logic             out1_valid,
  output logic             out1_sol,
  output logic             out1_sof,
  output logic [PIX_W-1:0] out1_pix,
  output logic             cfg_err
);

  localparam int HALF_MAX = MAX_WIDTH / 2;
  localparam int AW       = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
  localparam int LANES    = 2;

  // Named internal events, also used by the bound checker.
  logic             frame_load;
  logic             is_split;
  logic             left_hit;
  logic             right_hit;
  route_e           eff_route;
  route_e           route_q;
  logic [CFG_W-1:0] eff_width, eff_height, half_w;
  logic [CFG_W-1:0] cur_col, cur_row, right_idx;
  logic [PIX_W-1:0] left_rd;

  assign frame_load = in_valid & in_sof;

  lrs_cfg #(.CFG_W(CFG_W), .MAX_WIDTH(MAX_WIDTH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_load(frame_load), .eff_width(eff_width),
    .eff_height(eff_height), .eff_route(eff_route), .route_q(route_q),
    .err(cfg_err)
  );

  lrs_pos #(.CFG_W(CFG_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .cur_col(cur_col), .cur_row(cur_row)
  );

  always_comb begin
    half_w    = CFG_W'(half_of(32'(eff_width)));
    is_split  = (eff_route == ROUTE_SPLIT);
    right_idx = cur_col - half_w;
    left_hit  = in_valid & is_split & (cur_row < eff_height) & (cur_col < half_w);
    right_hit = in_valid & is_split & (cur_row < eff_height) &
                (cur_col >= half_w) & (cur_col < eff_width);
  end

  lrs_halfbuf #(.DEPTH(HALF_MAX), .PIX_W(PIX_W), .AW(AW)) u_buf (
    .clk(clk), .we(left_hit), .waddr(cur_col[AW-1:0]), .wdata(in_pix),
    .raddr(right_idx[AW-1:0]), .rdata(left_rd)
  );

  logic [LANES-1:0] nx_v, nx_sol, nx_sof, q_v, q_sol, q_sof;
  logic [PIX_W-1:0] nx_pix [LANES];
  logic [PIX_W-1:0] q_pix  [LANES];

  always_comb begin
    nx_v      = '0;
    nx_sol    = '0;
    nx_sof    = '0;
    nx_pix[0] = '0;
    nx_pix[1] = '0;
    if (in_valid && !is_split) begin
      nx_v[0]   = 1'b1;
      nx_sol[0] = in_sol;
      nx_sof[0] = in_sof;
      nx_pix[0] = in_pix;
    end else if (right_hit) begin
      nx_v      = '1;
      nx_sol    = {LANES{right_idx == '0}};
      nx_sof    = {LANES{(right_idx == '0) && (cur_row == '0)}};
      nx_pix[0] = left_rd;
      nx_pix[1] = in_pix;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_v[g]   <= 1'b0;
        q_sol[g] <= 1'b0;
        q_sof[g] <= 1'b0;
        q_pix[g] <= '0;
      end else begin
        q_v[g]   <= nx_v[g];
        q_sol[g] <= nx_sol[g];
        q_sof[g] <= nx_sof[g];
        q_pix[g] <= nx_pix[g];
      end
    end
  end

  assign out0_valid = q_v[0];
  assign out0_sol   = q_sol[0];
  assign out0_sof   = q_sof[0];
  assign out0_pix   = q_pix[0];
  assign out1_valid = q_v[1];
  assign out1_sol   = q_sol[1];
  assign out1_sof   = q_sof[1];
  assign out1_pix   = q_pix[1];

endmodule

// File: rtl/lrs_checker.sv
module lrs_checker
  import lrs_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_pix,
  input logic             frame_load,
  input route_e           route_q,
  input logic             out0_valid,
  input logic             out0_sol,
  input logic             out0_sof,
  input logic [PIX_W-1:0] out0_pix,
  input logic             out1_valid,
  input logic             out1_sol,
  input logic             out1_sof,
  input logic [PIX_W-1:0] out1_pix,
  input logic             cfg_err
);

  p_lanes_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out1_valid |-> (out0_valid && out1_sol == out0_sol && out1_sof == out0_sof));

  p_right_is_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out1_valid |-> out1_pix == $past(in_pix));

  p_valid_from_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out0_valid |-> $past(in_valid));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out0_valid |-> (out0_pix == '0 && !out0_sol && !out0_sof)) and
    (!out1_valid |-> (out1_pix == '0 && !out1_sol && !out1_sof)));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  p_route_frame_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_load |=> $stable(route_q));

endmodule

bind lr_line_splitter lrs_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
  .frame_load(frame_load), .route_q(route_q),
  .out0_valid(out0_valid), .out0_sol(out0_sol), .out0_sof(out0_sof),
  .out0_pix(out0_pix), .out1_valid(out1_valid), .out1_sol(out1_sol),
  .out1_sof(out1_sof), .out1_pix(out1_pix), .cfg_err(cfg_err)
);

// File: tb/lr_line_splitter_test.sv
module lr_line_splitter_test;

  localparam int PIX_W = 24;
  localparam int CFG_W = 16;
  localparam int MAXW  = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic             in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic [PIX_W-1:0] in_pix = '0;
  logic             out0_valid, out0_sol, out0_sof, out1_valid, out1_sol, out1_sof;
  logic [PIX_W-1:0] out0_pix, out1_pix;
  logic             cfg_err;

  lr_line_splitter #(.PIX_W(PIX_W), .CFG_W(CFG_W), .MAX_WIDTH(MAXW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .in_pix(in_pix), .out0_valid(out0_valid),
    .out0_sol(out0_sol), .out0_sof(out0_sof), .out0_pix(out0_pix),
    .out1_valid(out1_valid), .out1_sol(out1_sol), .out1_sof(out1_sof),
    .out1_pix(out1_pix), .cfg_err(cfg_err)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;

  // Bench model state.
  int unsigned sh_w = 0, sh_h = 0, sh_mode = 0, sh_en = 0;
  int unsigned act_w = 0, act_h = 0;
  bit          act_split = 0, m_err = 0;
  int unsigned m_col = 0, m_row = 0;
  logic [PIX_W-1:0] m_left [MAXW];

  function automatic bit legal_w(int unsigned w);
    return w > 0 && (w & 1) == 0 && w <= MAXW;
  endfunction

  function automatic bit wants_split(int unsigned mode, int unsigned en);
    return mode[3] && mode[0] && !mode[2] && en[0];
  endfunction

  task automatic step(bit v, bit sol, bit sof, logic [PIX_W-1:0] pix, string tag);
    logic [PIX_W+2:0] e0, e1, a0, a1;
    int unsigned col, row, half;
    if (v && sof) begin
      act_w = sh_w; act_h = sh_h;
      act_split = wants_split(sh_mode, sh_en) && legal_w(sh_w);
      if (wants_split(sh_mode, sh_en) && !legal_w(sh_w)) m_err = 1;
    end
    col = sol ? 0 : m_col;
    row = sof ? 0 : (sol ? m_row + 1 : m_row);
    half = act_w / 2;
    e0 = '0; e1 = '0;
    if (v && !act_split) e0 = {1'b1, sol, sof, pix};
    else if (v && row < act_h && col >= half && col < act_w) begin
      e0 = {1'b1, col == half, col == half && row == 0, m_left[col - half]};
      e1 = {1'b1, col == half, col == half && row == 0, pix};
    end
    in_valid = v; in_sol = sol; in_sof = sof; in_pix = pix;
    @(posedge clk); #1;
    a0 = {out0_valid, out0_sol, out0_sof, out0_pix};
    a1 = {out1_valid, out1_sol, out1_sof, out1_pix};
    vectors++;
    if (a0 !== e0 || a1 !== e1 || cfg_err !== m_err) begin
      errors++;
      $display("FAIL %s: actual lane0=%h lane1=%h err=%b expected lane0=%h lane1=%h err=%b",
               tag, a0, a1, cfg_err, e0, e1, m_err);
    end
    if (v) begin
      if (act_split && row < act_h && col < half) m_left[col] = pix;
      m_col = col + 1; m_row = row;
    end
    @(negedge clk);
    in_valid = 0; in_sol = 0; in_sof = 0; in_pix = '0;
  endtask

  task automatic cfg_wr(int unsigned addr, int unsigned data, string tag);
    cfg_we = 1; cfg_addr = 2'(addr); cfg_wdata = CFG_W'(data);
    case (addr)
      0: sh_w = data & 16'hFFFF;
      1: sh_h = data & 16'hFFFF;
      2: sh_mode = data & 4'hF;
      default: sh_en = data & 1;
    endcase
    step(0, 0, 0, '0, tag);
    cfg_we = 0;
  endtask

  task automatic send_line(bit first, int unsigned npix, int unsigned gap_pct, string tag);
    for (int p = 0; p < int'(npix); p++) begin
      while (($urandom % 100) < gap_pct) step(0, 0, 0, '0, "R9");
      step(1, p == 0, first && p == 0, PIX_W'($urandom), tag);
    end
  endtask

  task automatic send_frame(int unsigned nlines, int unsigned npix, int unsigned gap_pct, string tag);
    for (int l = 0; l < int'(nlines); l++) begin
      send_line(l == 0, npix, gap_pct, tag);
      step(0, 0, 0, '0, "R9");
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < MAXW; i++) m_left[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state is idle and bypassing
    step(0, 0, 0, '0, "R10");
    send_frame(2, 6, 20, "R10 R3");
    // R3: bypass with gaps
    send_frame(3, 9, 40, "R3");
    // R8: config written mid-frame must not alter the running frame
    send_line(1, 8, 0, "R8");
    cfg_wr(0, 8, "R1");
    cfg_wr(1, 3, "R1");
    cfg_wr(2, 9, "R1");
    cfg_wr(3, 1, "R1");
    send_line(0, 8, 10, "R8");
    send_line(0, 8, 10, "R8");
    // R4 R5 R6: split frame with extra columns and an extra line
    send_frame(4, 10, 15, "R4 R5 R6");
    send_frame(3, 8, 0, "R4 R5");
    // R2: routing variants that must bypass
    cfg_wr(2, 13, "R2");
    send_frame(2, 8, 10, "R2");
    cfg_wr(2, 9, "R2");
    cfg_wr(3, 0, "R2");
    send_frame(2, 8, 10, "R2");
    cfg_wr(2, 1, "R2");
    cfg_wr(3, 1, "R2");
    send_frame(2, 8, 10, "R2");
    cfg_wr(2, 9, "R2");
    // R7: odd, oversize, zero widths
    cfg_wr(0, 7, "R7");
    send_frame(2, 7, 10, "R7");
    cfg_wr(0, MAXW + 2, "R7");
    send_frame(2, 10, 10, "R7");
    cfg_wr(0, 0, "R7");
    send_frame(1, 4, 0, "R7");
    // R4: largest legal width
    cfg_wr(0, MAXW, "R4");
    cfg_wr(1, 2, "R6");
    send_frame(3, MAXW, 5, "R4 R6");
    // Random legal frames
    for (int f = 0; f < 12; f++) begin
      int unsigned w, h;
      w = 2 * (1 + $urandom % (MAXW / 2));
      h = 1 + $urandom % 4;
      cfg_wr(0, w, "R1");
      cfg_wr(1, h, "R1");
      send_frame(h + $urandom % 2, w + $urandom % 3, $urandom % 30, "R4 R5 R6");
    end
    repeat (3) step(0, 0, 0, '0, "R9");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule